// File: doc/BRIEF.md
# Filtered Quadrature Clock Decoder

This block turns the two raw signals of an incremental encoder into count enables for one axis. Both inputs are first brought into the system clock domain through a synchronizer chain. Each is then passed through a stability filter, which accepts a new level only after the raw level has differed from the held level for a set number of consecutive filter ticks. A 2-bit prescale input slows the filter tick, so slower or noisier encoders can be rejected more strongly.

The filtered pair is decoded according to a 3-bit mode field. There are three quadrature resolutions: every edge, both edges of channel A, or one edge of A per encoder cycle. There is also a clock-and-direction mode, in which A is the count clock and B is the direction level. Each accepted transition yields one single-cycle up or down enable for a downstream counter. A direction output holds the sense of the most recent count, and a sticky flag records any quadrature step in which both inputs changed together.

Top module: `qdec_axis`

## Requirements
- R1: With `mode_cfg` = 3 (x4), every change of exactly one filtered input gives one enable pulse. The forward order (A,B) = 00→10→11→01→00 pulses `cnt_up`, and the reverse order pulses `cnt_dn`.
- R2: With `mode_cfg` = 2 (x2), only changes of A give a pulse, with the same direction sense as in x4. Changes of B alone give none.
- R3: With `mode_cfg` = 1 (x1), `cnt_up` pulses only on a rising A while B is low (forward). `cnt_dn` pulses only on a falling A while B is low (reverse). No other transition counts.
- R4: With `mode_cfg` = 4 (clock and direction), each rising edge of filtered A gives one pulse: `cnt_up` if B is high, `cnt_dn` if B is low. A falling A and any change of B alone give no pulse.
- R5: With `flt_psc` = 0, a raw input pulse lasting 2 clocks gives no count, and a pulse lasting 5 clocks is accepted. A new level needs 3 consecutive differing filter ticks (parameter `STABLE_TICKS`).
- R6: `flt_psc` = p sets one filter tick every 2^p clocks. With p = 3, a 12-clock raw pulse is rejected, while a level held for 40 clocks is accepted.
- R7: In a quadrature mode (1, 2 or 3), a step where both filtered inputs change in the same cycle gives no pulse and sets `quad_err`. `quad_err` stays set until reset and is never set in mode 4.
- R8: Mode codes 0, 5, 6 and 7 are disabled. No pulse is produced on either enable.
- R9: Each accepted transition gives exactly one pulse of one clock on one enable. `cnt_up` and `cnt_dn` are never high together.
- R10: `dir_up` goes to 1 with each `cnt_up` pulse and to 0 with each `cnt_dn` pulse. It holds its value otherwise.
- R11: After reset, `cnt_up`, `cnt_dn` and `quad_err` are 0 and `dir_up` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Raw encoder channel A (asynchronous) |
| enc_b | input | 1 | Raw encoder channel B (asynchronous) |
| mode_cfg | input | 3 | 1 x1, 2 x2, 3 x4, 4 clock/direction, others disabled |
| flt_psc | input | 2 | Filter tick every 2^flt_psc clocks |
| cnt_up | output | 1 | One-clock count-up enable |
| cnt_dn | output | 1 | One-clock count-down enable |
| dir_up | output | 1 | Direction of the most recent count, 1 = up |
| quad_err | output | 1 | Sticky flag for a both-inputs-changed step |

## Verification
The decoder is walked through full forward and reverse Gray cycles in each of x4, x2 and x1. The per-step pulse counts separate the three resolutions, and the reverse half shows that direction follows the phase relation rather than which input moved. The clock-and-direction mode is driven with B toggled alone, and with A rising and falling under both B levels. This shows that only rising A counts and that B picks the sign. Short and long raw pulses at two prescale settings locate the filter threshold. A simultaneous change of both inputs, followed by legal steps, checks both the suppression of the count and the stickiness of the error flag.

// File: rtl/qdec_pkg.sv
// Shared mode encoding for the quadrature decoder.
// Assumes: codes not listed here are treated as disabled.
package qdec_pkg;
    typedef enum logic [2:0] {
        QM_OFF = 3'd0,
        QM_X1  = 3'd1,
        QM_X2  = 3'd2,
        QM_X4  = 3'd3,
        QM_CD  = 3'd4
    } qmode_e;
endpackage

// File: rtl/qdec_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is sampled independently; no bus coherence is needed.
module qdec_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    // Shift raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/qdec_tick.sv
// Filter tick generator: one-cycle tick every 2^psc clocks.
// Assumes: psc may change at any time; the next tick then follows the new rate.
module qdec_tick #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    // Low psc bits of the divider select the tick period.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(psc));
    end

    assign tick = ((div_cnt & mask) == '0);
endmodule

// File: rtl/qdec_filter.sv
// Level filter: adopts the raw level after STABLE_TICKS consecutive
// ticks on which it differs from the held level.
// Assumes: raw is already synchronous to clk.
module qdec_filter #(
    parameter int STABLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic lvl
);
    localparam int CW = $clog2(STABLE_TICKS + 1);

    logic [CW-1:0] run;

    // Count differing ticks; accept on the last one, restart on agreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= 1'b0;
            run <= '0;
        end else if (tick) begin
            if (raw == lvl) begin
                run <= '0;
            end else if (run == CW'(STABLE_TICKS - 1)) begin
                lvl <= raw;
                run <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end
endmodule

// File: rtl/qdec_decode.sv
// Transition decoder: compares filtered A/B with their previous values
// and issues registered up/down enables, direction and a sticky error.
// Assumes: fa/fb change at most once per clock each.
module qdec_decode
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       fa,
    input  logic       fb,
    output logic       up,
    output logic       dn,
    output logic       dir,
    output logic       err
);
    logic pa, pb;
    logic da, db, only_a, only_b, both;
    logic fwd_a, fwd_b;
    logic up_c, dn_c, err_c;

    // Remember the previous filtered pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa <= 1'b0;
            pb <= 1'b0;
        end else begin
            pa <= fa;
            pb <= fb;
        end
    end

    assign da     = fa ^ pa;
    assign db     = fb ^ pb;
    assign only_a = da & ~db;
    assign only_b = db & ~da;
    assign both   = da & db;
    assign fwd_a  = fa ^ fb;
    assign fwd_b  = ~(fa ^ fb);

    // Select which transitions count under the configured mode.
    always_comb begin
        up_c  = 1'b0;
        dn_c  = 1'b0;
        err_c = 1'b0;
        case (mode)
            QM_X4: begin
                up_c  = (only_a & fwd_a) | (only_b & fwd_b);
                dn_c  = (only_a & ~fwd_a) | (only_b & ~fwd_b);
                err_c = both;
            end
            QM_X2: begin
                up_c  = only_a & fwd_a;
                dn_c  = only_a & ~fwd_a;
                err_c = both;
            end
            QM_X1: begin
                up_c  = only_a & fa & fwd_a;
                dn_c  = only_a & ~fa & ~fwd_a;
                err_c = both;
            end
            QM_CD: begin
                up_c  = da & fa & fb;
                dn_c  = da & fa & ~fb;
            end
            default: ;
        endcase
    end

    // Register enables, direction and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up  <= 1'b0;
            dn  <= 1'b0;
            dir <= 1'b1;
            err <= 1'b0;
        end else begin
            up  <= up_c;
            dn  <= dn_c;
            err <= err | err_c;
            if (up_c)      dir <= 1'b1;
            else if (dn_c) dir <= 1'b0;
        end
    end
endmodule

// File: rtl/qdec_axis.sv
// One-axis filtered quadrature decoder: synchronizer, per-channel
// stability filter, and mode-driven transition decoder.
// Assumes: enc_a/enc_b are asynchronous; mode_cfg and flt_psc are quasi-static.
module qdec_axis #(
    parameter int SYNC_STAGES  = 2,
    parameter int STABLE_TICKS = 3,
    parameter int PSC_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic [2:0]       mode_cfg,
    input  logic [PSC_W-1:0] flt_psc,
    output logic             cnt_up,
    output logic             cnt_dn,
    output logic             dir_up,
    output logic             quad_err
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_s;
    logic [NCH-1:0] lvl_f;
    logic           ftick;

    qdec_sync #(.W(NCH), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst_n (rst_n),
        .din ({enc_b, enc_a}),
        .dout (raw_s)
    );

    qdec_tick #(.PSC_W(PSC_W)) tick_i (
        .clk (clk),
        .rst_n (rst_n),
        .psc (flt_psc),
        .tick (ftick)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_flt
        qdec_filter #(.STABLE_TICKS(STABLE_TICKS)) flt_i (
            .clk (clk),
            .rst_n (rst_n),
            .tick (ftick),
            .raw (raw_s[ch]),
            .lvl (lvl_f[ch])
        );
    end

    qdec_decode dec_i (
        .clk (clk),
        .rst_n (rst_n),
        .mode (mode_cfg),
        .fa (lvl_f[0]),
        .fb (lvl_f[1]),
        .up (cnt_up),
        .dn (cnt_dn),
        .dir (dir_up),
        .err (quad_err)
    );
endmodule

// File: rtl/qdec_axis_chk.sv
// Property checker for qdec_axis, attached by bind.
// Assumes: observes top-level ports only.
module qdec_axis_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_cfg,
    input logic       cnt_up,
    input logic       cnt_dn,
    input logic       dir_up,
    input logic       quad_err
);
    function automatic logic is_off(input logic [2:0] m);
        return !(m inside {3'd1, 3'd2, 3'd3, 3'd4});
    endfunction

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_up && cnt_dn));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        quad_err |=> quad_err);

    p_cd_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_cfg) == 3'd4 && !$past(quad_err)) |-> !quad_err);

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_off($past(mode_cfg)) |-> (!cnt_up && !cnt_dn));

    p_dir_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_up |-> dir_up);

    p_dir_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dn |-> !dir_up);
endmodule

bind qdec_axis qdec_axis_chk chk_i (
    .clk (clk),
    .rst_n (rst_n),
    .mode_cfg (mode_cfg),
    .cnt_up (cnt_up),
    .cnt_dn (cnt_dn),
    .dir_up (dir_up),
    .quad_err (quad_err)
);

// File: tb/qdec_axis_tb_top.sv
module qdec_axis_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_a = 1'b0;
    logic       enc_b = 1'b0;
    logic [2:0] mode_cfg = 3'd3;
    logic [1:0] flt_psc = 2'd0;
    logic       cnt_up, cnt_dn, dir_up, quad_err;

    int total = 0;
    int bad = 0;
    int tot_up = 0;
    int tot_dn = 0;
    int overlap = 0;

    always #4 clk = ~clk;

    qdec_axis dut_i (
        .clk (clk),
        .rst_n (rst_n),
        .enc_a (enc_a),
        .enc_b (enc_b),
        .mode_cfg (mode_cfg),
        .flt_psc (flt_psc),
        .cnt_up (cnt_up),
        .cnt_dn (cnt_dn),
        .dir_up (dir_up),
        .quad_err (quad_err)
    );

    // Pulse monitor (R9: both enables high together is an overlap)
    always @(negedge clk) begin
        if (rst_n) begin
            if (cnt_up) tot_up++;
            if (cnt_dn) tot_dn++;
            if (cnt_up && cnt_dn) overlap++;
        end
    end

    typedef struct packed {
        logic [3:0] req;
        logic [2:0] mode;
        logic       a;
        logic       b;
        logic [1:0] eu;
        logic [1:0] ed;
        logic       dir;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        // R1 x4 forward then reverse
        '{4'd1, 3'd3, 1'b1, 1'b0, 2'd1, 2'd0, 1'b1},
        '{4'd1, 3'd3, 1'b1, 1'b1, 2'd1, 2'd0, 1'b1},
        '{4'd1, 3'd3, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1},
        '{4'd1, 3'd3, 1'b0, 1'b0, 2'd1, 2'd0, 1'b1},
        '{4'd1, 3'd3, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0},
        '{4'd1, 3'd3, 1'b1, 1'b1, 2'd0, 2'd1, 1'b0},
        '{4'd1, 3'd3, 1'b1, 1'b0, 2'd0, 2'd1, 1'b0},
        '{4'd1, 3'd3, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0},
        // R2 x2
        '{4'd2, 3'd2, 1'b1, 1'b0, 2'd1, 2'd0, 1'b1},
        '{4'd2, 3'd2, 1'b1, 1'b1, 2'd0, 2'd0, 1'b1},
        '{4'd2, 3'd2, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1},
        '{4'd2, 3'd2, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1},
        '{4'd2, 3'd2, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1},
        '{4'd2, 3'd2, 1'b1, 1'b1, 2'd0, 2'd1, 1'b0},
        '{4'd2, 3'd2, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0},
        '{4'd2, 3'd2, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0},
        // R3 x1
        '{4'd3, 3'd1, 1'b1, 1'b0, 2'd1, 2'd0, 1'b1},
        '{4'd3, 3'd1, 1'b1, 1'b1, 2'd0, 2'd0, 1'b1},
        '{4'd3, 3'd1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1},
        '{4'd3, 3'd1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1},
        '{4'd3, 3'd1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1},
        '{4'd3, 3'd1, 1'b1, 1'b1, 2'd0, 2'd0, 1'b1},
        '{4'd3, 3'd1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1},
        '{4'd3, 3'd1, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0},
        // R4 clock/direction
        '{4'd4, 3'd4, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0},
        '{4'd4, 3'd4, 1'b1, 1'b1, 2'd1, 2'd0, 1'b1},
        '{4'd4, 3'd4, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1},
        '{4'd4, 3'd4, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1},
        '{4'd4, 3'd4, 1'b1, 1'b0, 2'd0, 2'd1, 1'b0},
        '{4'd4, 3'd4, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
        // R8 disabled codes
        '{4'd8, 3'd0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0},
        '{4'd8, 3'd0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0},
        '{4'd8, 3'd5, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0},
        '{4'd8, 3'd6, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
        '{4'd8, 3'd7, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0},
        '{4'd8, 3'd7, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a level pair, hold, and report pulses seen in that window
    task automatic step(input logic a, input logic b, input int hold,
                        output int nu, output int nd);
        int u0, d0;
        @(negedge clk);
        u0 = tot_up;
        d0 = tot_dn;
        enc_a = a;
        enc_b = b;
        repeat (hold) @(negedge clk);
        nu = tot_up - u0;
        nd = tot_dn - d0;
    endtask

    task automatic pulse_a(input int width, input int settle,
                           output int nu, output int nd);
        int u0, d0;
        @(negedge clk);
        u0 = tot_up;
        d0 = tot_dn;
        enc_a = 1'b1;
        repeat (width) @(negedge clk);
        enc_a = 1'b0;
        repeat (settle) @(negedge clk);
        nu = tot_up - u0;
        nd = tot_dn - d0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nu, nd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 cnt_up", int'(cnt_up), 0);
        check("R11 cnt_dn", int'(cnt_dn), 0);
        check("R11 dir_up", int'(dir_up), 1);
        check("R11 quad_err", int'(quad_err), 0);

        // Table walk: R1 R2 R3 R4 R8 with R10 direction
        for (int i = 0; i < NV; i++) begin
            mode_cfg = VEC[i].mode;
            step(VEC[i].a, VEC[i].b, 20, nu, nd);
            check($sformatf("R%0d row %0d up", VEC[i].req, i), nu, int'(VEC[i].eu));
            check($sformatf("R%0d row %0d dn", VEC[i].req, i), nd, int'(VEC[i].ed));
            check($sformatf("R10 row %0d dir", i), int'(dir_up), int'(VEC[i].dir));
        end
        check("R7 no error from table", int'(quad_err), 0);

        // R5 filter threshold at psc 0
        mode_cfg = 3'd3;
        flt_psc = 2'd0;
        pulse_a(2, 20, nu, nd);
        check("R5 2-clock glitch up", nu, 0);
        check("R5 2-clock glitch dn", nd, 0);
        pulse_a(5, 20, nu, nd);
        check("R5 5-clock pulse up", nu, 1);
        check("R5 5-clock pulse dn", nd, 1);

        // R6 prescale 3: tick every 8 clocks
        flt_psc = 2'd3;
        pulse_a(12, 60, nu, nd);
        check("R6 12-clock pulse rejected up", nu, 0);
        check("R6 12-clock pulse rejected dn", nd, 0);
        step(1'b1, 1'b0, 40, nu, nd);
        check("R6 long level accepted", nu, 1);
        step(1'b0, 1'b0, 40, nu, nd);
        check("R6 long level back", nd, 1);
        flt_psc = 2'd0;

        // R7 both inputs change together in x4
        step(1'b1, 1'b1, 20, nu, nd);
        check("R7 illegal step up", nu, 0);
        check("R7 illegal step dn", nd, 0);
        check("R7 error set", int'(quad_err), 1);
        step(1'b0, 1'b0, 20, nu, nd);
        check("R7 illegal return no count", nu + nd, 0);
        step(1'b1, 1'b0, 20, nu, nd);
        check("R7 legal step after error", nu, 1);
        check("R7 error sticky", int'(quad_err), 1);
        step(1'b0, 1'b0, 20, nu, nd);
        check("R7 legal reverse after error", nd, 1);

        // R9 never both enables
        check("R9 overlap cycles", overlap, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule